// File: doc/BRIEF.md
# Configurable Reversible Chain Gate

This block is a purely combinational reversible gate over `N` lines, where `N` may be anything from 1 to 8. Each output line is built from the inputs through a chained XOR/AND rule that is defined over logical roles a1..aN. The roles a1 and a2 get inversions, a1..a3 share a short XOR mix, and every later role flips only when all earlier role outputs are 1.

A run-time ordering word decides which physical line takes each role. With it, one datapath gives every one of the N! gate variants. The ordering word holds N fields, each `W` bits wide, where `W` is ceil(log2 N) with a minimum of 1. Field r sits at bits `[r*W +: W]` and names the line, numbered from 0, that plays role a(r+1). Line p is bit p of the data vectors.

When the ordering word is not a permutation of the lines 0..N-1, the block raises a flag and passes the data through unchanged. Because of this, the mapping stays a bijection for every value of the ordering word. There is no clock and no state: the outputs follow the inputs combinationally.

Top module: `perm_mgate`

## Requirements
- R1: With N=1 and ordering field 0, `data_out` is the inverse of `data_in`.
- R2: With N=2, the role-a1 output is the inverted role-a1 input. The role-a2 output is the role-a2 input XOR the role-a1 input XOR 1.
- R3: With N≥3, the role-a3 output is x_a3 XOR x_a2, and the role-a1 output is x_a1 XOR that role-a3 output.
- R4: With N≥3, the role-a2 output is NOT x_a2 XOR (role-a3 output AND role-a1 output).
- R5: For every role am with m≥4, the output is x_am XOR the AND of the outputs of roles a1 through a(m-1).
- R6: Field r of `order_in`, at bits `[r*W +: W]` with W = ceil(log2 N) and a minimum of 1, gives the 0-based line index p, meaning `data_in[p]`, that plays role a(r+1).
- R7: If any field is N or larger, or two fields are equal, `order_bad` is 1 and `data_out` equals `data_in`. Otherwise `order_bad` is 0.
- R8: For every valid ordering, the 2^N output values over all 2^N inputs are all distinct.
- R9: With N=3 and fields (role a1, a2, a3) = (2, 1, 0), that is `order_in` = 6'b000110, the mapping on input values is the single 8-cycle 0→2→7→4→6→1→5→3→0.
- R10: With N=3, the six valid orderings produce six different mappings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | N | Input line values; bit p is line p |
| order_in | input | N*W | Role-to-line assignment, one W-bit field per role |
| data_out | output | N | Output line values after the gate, or `data_in` when the ordering is invalid |
| order_bad | output | 1 | High when the ordering word is not a permutation of 0..N-1 |

## Verification
The hardest cases to bring about are ordering words that look plausible but are illegal. One kind repeats a line index while every field stays in range. The other kind holds only distinct fields, but one of them points at a line index that does not exist, which happens when N is not a power of two. A few directed codes would rarely hit both kinds together with every data value. The stimulus therefore sweeps the entire ordering code space, legal and illegal, against every data word for N = 1, 2, 3 and 4. For each legal ordering it also collects the full output image to confirm the mapping is a bijection, and for N=3 it compares the six resulting mappings against each other.

// File: rtl/perm_mgate_pkg.sv
package perm_mgate_pkg;

    // Width of one ordering field for an n-line gate (at least one bit).
    function automatic int fld_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pm_order_decode.sv
module pm_order_decode #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N*W-1:0]        order_code,
    output logic [N-1:0][N-1:0]   role_sel,
    output logic                  order_ok
);

    // One-hot select: role_sel[r][p] is set when role r names line p.
    for (genvar r = 0; r < N; r++) begin : g_role
        for (genvar p = 0; p < N; p++) begin : g_line
            assign role_sel[r][p] = (order_code[r*W +: W] == W'(p));
        end
    end

    // Legal only when every line is claimed by exactly one role.
    always_comb begin
        logic [N-1:0] col;
        order_ok = 1'b1;
        for (int p = 0; p < N; p++) begin
            col = '0;
            for (int r = 0; r < N; r++) col[r] = role_sel[r][p];
            if (!$onehot(col)) order_ok = 1'b0;
        end
    end

    always_comb begin
        if (order_ok) begin
            for (int r = 0; r < N; r++) begin
                // R7
                row_onehot_chk: assert ($onehot(role_sel[r]));
            end
        end
    end

endmodule

// File: rtl/pm_role_gather.sv
module pm_role_gather #(
    parameter int N = 4
) (
    input  logic [N-1:0][N-1:0] role_sel,
    input  logic [N-1:0]        line_in,
    output logic [N-1:0]        role_x
);

    for (genvar r = 0; r < N; r++) begin : g_pick
        assign role_x[r] = |(role_sel[r] & line_in);
    end

endmodule

// File: rtl/pm_role_chain.sv
module pm_role_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] role_x,
    output logic [N-1:0] role_y
);

    if (N == 1) begin : g_one
        assign role_y[0] = ~role_x[0];
    end else if (N == 2) begin : g_two
        assign role_y[0] = ~role_x[0];
        assign role_y[1] = role_x[1] ^ ~role_x[0];
        always_comb begin
            // R2
            two_line_inv_chk: assert ((role_y[0] ^ role_y[1]) == role_x[1]);
        end
    end else begin : g_many
        always_comb begin
            logic [N-1:0] ry;
            logic         acc;
            ry    = '0;
            ry[2] = role_x[2] ^ role_x[1];
            ry[0] = role_x[0] ^ ry[2];
            ry[1] = ~role_x[1] ^ (ry[2] & ry[0]);
            acc   = ry[0] & ry[1] & ry[2];
            for (int m = 3; m < N; m++) begin
                ry[m] = role_x[m] ^ acc;
                acc   = acc & ry[m];
            end
            role_y = ry;
        end

        always_comb begin
            // R3
            a1_recover_chk: assert ((role_y[0] ^ role_y[2]) == role_x[0]);
            // R4
            a2_recover_chk: assert ((~(role_y[1] ^ (role_y[2] & role_y[0]))) == role_x[1]);
        end
    end

endmodule

// File: rtl/pm_role_scatter.sv
module pm_role_scatter #(
    parameter int N = 4
) (
    input  logic [N-1:0][N-1:0] role_sel,
    input  logic [N-1:0]        role_y,
    output logic [N-1:0]        line_out
);

    always_comb begin
        logic [N-1:0] col;
        for (int p = 0; p < N; p++) begin
            col = '0;
            for (int r = 0; r < N; r++) col[r] = role_sel[r][p];
            line_out[p] = |(col & role_y);
        end
    end

endmodule

// File: rtl/perm_mgate.sv
module perm_mgate #(
    parameter int N = 4,
    localparam int W = perm_mgate_pkg::fld_w(N)
) (
    input  logic [N-1:0]   data_in,
    input  logic [N*W-1:0] order_in,
    output logic [N-1:0]   data_out,
    output logic           order_bad
);

    logic [N-1:0][N-1:0] role_sel;
    logic                order_ok;
    logic [N-1:0]        role_x;
    logic [N-1:0]        role_y;
    logic [N-1:0]        mapped;

    pm_order_decode #(.N(N), .W(W)) u_decode (
        .order_code (order_in),
        .role_sel   (role_sel),
        .order_ok   (order_ok)
    );

    pm_role_gather #(.N(N)) u_gather (
        .role_sel (role_sel),
        .line_in  (data_in),
        .role_x   (role_x)
    );

    pm_role_chain #(.N(N)) u_chain (
        .role_x (role_x),
        .role_y (role_y)
    );

    pm_role_scatter #(.N(N)) u_scatter (
        .role_sel (role_sel),
        .role_y   (role_y),
        .line_out (mapped)
    );

    assign order_bad = ~order_ok;
    assign data_out  = order_ok ? mapped : data_in;

    always_comb begin
        // R7
        bypass_chk: assert (!order_bad || (data_out == data_in));
        // R1
        if (N == 1 && order_ok) begin
            single_line_chk: assert (data_out != data_in);
        end
    end

endmodule

// File: tb/perm_mgate_tb.sv
module perm_mgate_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [3:0] d4, q4;  logic [7:0] o4; logic b4;
    logic [2:0] d3, q3;  logic [5:0] o3; logic b3;
    logic [1:0] d2, q2;  logic [1:0] o2; logic b2;
    logic [0:0] d1, q1;  logic [0:0] o1; logic b1;

    perm_mgate #(.N(4)) u_dut  (.data_in(d4), .order_in(o4), .data_out(q4), .order_bad(b4));
    perm_mgate #(.N(3)) u_dut3 (.data_in(d3), .order_in(o3), .data_out(q3), .order_bad(b3));
    perm_mgate #(.N(2)) u_dut2 (.data_in(d2), .order_in(o2), .data_out(q2), .order_bad(b2));
    perm_mgate #(.N(1)) u_dut1 (.data_in(d1), .order_in(o1), .data_out(q1), .order_bad(b1));

    function automatic int fw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Behavioural model of the requirements: returns mapped value, sets bad.
    function automatic int ref_m(input int n, input int code, input int x, output bit bad);
        int w, f[8], xr[8], yr[8], acc, res;
        w = fw(n);
        bad = 1'b0;
        for (int r = 0; r < n; r++) begin
            f[r] = (code >> (r * w)) & ((1 << w) - 1);
            if (f[r] >= n) bad = 1'b1;
        end
        for (int a = 0; a < n; a++)
            for (int b = a + 1; b < n; b++)
                if (f[a] == f[b]) bad = 1'b1;
        if (bad) return x;
        for (int r = 0; r < n; r++) xr[r] = (x >> f[r]) & 1;
        if (n == 1) begin
            yr[0] = 1 - xr[0];
        end else if (n == 2) begin
            yr[0] = 1 - xr[0];
            yr[1] = xr[1] ^ yr[0];
        end else begin
            yr[2] = xr[2] ^ xr[1];
            yr[0] = xr[0] ^ yr[2];
            yr[1] = (1 - xr[1]) ^ (yr[2] & yr[0]);
            acc = yr[0] & yr[1] & yr[2];
            for (int m = 3; m < n; m++) begin
                yr[m] = xr[m] ^ acc;
                acc = acc & yr[m];
            end
        end
        res = 0;
        for (int r = 0; r < n; r++) res = res | (yr[r] << f[r]);
        return res;
    endfunction

    task automatic apply(input int n, input int code, input int x, output int q, output bit bad);
        @(posedge clk);
        #1;
        case (n)
            4: begin d4 = 4'(x); o4 = 8'(code); end
            3: begin d3 = 3'(x); o3 = 6'(code); end
            2: begin d2 = 2'(x); o2 = 2'(code); end
            default: begin d1 = 1'(x); o1 = 1'(code); end
        endcase
        @(negedge clk);
        case (n)
            4: begin q = int'(q4); bad = b4; end
            3: begin q = int'(q3); bad = b3; end
            2: begin q = int'(q2); bad = b2; end
            default: begin q = int'(q1); bad = b1; end
        endcase
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sweep(input int n, input string tag);
        int q, e, w, ncode;
        bit bad, ebad;
        longint seen;
        w = fw(n);
        ncode = 1 << (n * w);
        for (int code = 0; code < ncode; code++) begin
            seen = 0;
            for (int x = 0; x < (1 << n); x++) begin
                apply(n, code, x, q, bad);
                e = ref_m(n, code, x, ebad);
                check(bad == ebad, "R7 flag", int'(bad), int'(ebad));
                check(q == e, ebad ? "R7 bypass" : tag, q, e);
                seen = seen | (longint'(1) << q);
            end
            if (!ebad)
                check(seen == ((longint'(1) << (1 << n)) - 1), "R8 bijection",
                      int'(seen), int'((longint'(1) << (1 << n)) - 1));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int q;
        bit bad;
        int cyc[8];
        logic [23:0] maps[$];
        logic [23:0] mp;
        int nvalid;
        d4 = '0; o4 = '0; d3 = '0; o3 = '0; d2 = '0; o2 = '0; d1 = '0; o1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: all-zero ordering is illegal for N=4 (R7).
        check(b4 == 1'b1, "R7 reset flag", int'(b4), 1);
        check(q4 == d4, "R7 reset bypass", int'(q4), int'(d4));
        // N=1 ordering 0 is legal; zero input inverts (R1).
        check(q1 == 1'b1, "R1 reset", int'(q1), 1);
        rst = 1'b0;

        // R6: field layout on N=4.
        apply(4, 8'hE4, 0, q, bad);
        check(q == 4'b0010, "R6 order 0,1,2,3", q, 2);
        apply(4, 8'h1B, 0, q, bad);
        check(q == 4'b0100, "R6 order 3,2,1,0", q, 4);

        // R9: single 8-cycle for fields (2,1,0).
        cyc = '{2, 5, 7, 0, 6, 3, 1, 4};
        for (int x = 0; x < 8; x++) begin
            apply(3, 6, x, q, bad);
            check(q == cyc[x] && !bad, "R9 cycle", q, cyc[x]);
        end

        sweep(1, "R1 invert");
        sweep(2, "R2 two-line");
        sweep(3, "R3/R4 three-line");
        sweep(4, "R5 chain");

        // R10: six valid N=3 orderings give six distinct mappings.
        nvalid = 0;
        for (int code = 0; code < 64; code++) begin
            void'(ref_m(3, code, 0, bad));
            if (!bad) begin
                mp = '0;
                for (int x = 0; x < 8; x++) begin
                    apply(3, code, x, q, bad);
                    mp[x*3 +: 3] = 3'(q);
                end
                foreach (maps[i])
                    check(maps[i] != mp, "R10 distinct", int'(mp), -1);
                maps.push_back(mp);
                nvalid++;
            end
        end
        check(nvalid == 6, "R10 count", nvalid, 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule